// File: doc/BRIEF.md
# Configurable Four-Way Multiplexer Logic Element

This block is a six-input programmable logic element whose core is a single 4-to-1 multiplexer. Two logic inputs steer the select lines and four logic inputs feed the data lines. Each data line passes through its own programmable inverter before it reaches the multiplexer. The select lines have no inverter, because inverting a select would only reorder the data lines. The element therefore covers a fixed subset of six-input functions rather than all of them. Any two-input Boolean function can still be built by placing the two variables on the selects and tying the data lines to the truth-table constants.

A wrapper adds an output flip-flop. One configuration bit chooses whether the output comes from that flip-flop or straight from the multiplexer. The five configuration bits are shifted in serially, one bit per clock while the load enable is high. The reset clears only the output flip-flop and leaves the configuration as it was.

Top module: `mux4_le`

## Requirements
- R1: While cfg_en is high, each rising clock edge shifts the configuration word left by one place and puts cfg_din in bit 0. After five such edges, the first bit sent sits in bit 4.
- R2: While cfg_en is low, the configuration word does not change, whatever cfg_din does.
- R3: Configuration bit 4 selects the output mode: 0 means combinational and 1 means registered. In combinational mode, dout equals din[sel] XOR configuration bit sel in the same cycle, with sel read as an unsigned index from 0 to 3.
- R4: Configuration bits 0 to 3 each invert only the data input with the same index, independently of the other three bits.
- R5: The data inputs that sel does not pick have no effect on dout, and the select inputs are never inverted.
- R6: In registered mode, dout holds the value that R3 would give for the inputs present just before the previous rising edge. It changes only at a rising edge.
- R7: While rst_n is low, the output flip-flop is 0 and dout reads 0 in registered mode. After rst_n rises, the flip-flop stays 0 through the next two rising edges and loads the multiplexer value on the third.
- R8: Applying and releasing rst_n leaves the configuration word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain and the output flip-flop |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, most significant bit first |
| sel | input | 2 | Multiplexer select inputs |
| din | input | 4 | Multiplexer data inputs |
| dout | output | 1 | Element output |

## Verification
The assertions check on every cycle that the configuration chain shifts or holds as required, that combinational mode follows the selected and polarity-adjusted data input, and that registered mode returns the multiplexer value from one edge earlier. They also check that the flip-flop stays at 0 through the synchronised reset window. Only the bench scenarios can show the rest. Those scenarios sweep all 64 input combinations under several configurations in both modes. They confirm that a partial extra shift moves the whole word, and that a reset pulse leaves a loaded configuration working. They also count the exact edge on which the flip-flop comes out of reset.

// File: rtl/mux4_le_pkg.sv
package mux4_le_pkg;
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

  function automatic out_mode_e mode_of(input logic b);
    return b ? OUT_REG : OUT_COMB;
  endfunction
endpackage

// File: rtl/mux4_le_rst_sync.sv
module mux4_le_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/mux4_le_cfg_chain.sv
module mux4_le_cfg_chain #(
  parameter int CFG_W = 5
) (
  input  logic             clk,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic [CFG_W-1:0] cfg
);
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg;
    if (shift_en) cfg_d = {cfg[CFG_W-2:0], shift_in};
  end

  always_ff @(posedge clk) begin
    cfg <= cfg_d;
  end
endmodule

// File: rtl/mux4_le_datapath.sv
module mux4_le_datapath #(
  parameter int SEL_W  = 2,
  localparam int N_DAT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [N_DAT-1:0] din,
  input  logic [N_DAT-1:0] inv,
  output logic             y
);
  logic [N_DAT-1:0] pol;

  for (genvar i = 0; i < N_DAT; i++) begin : g_pol
    assign pol[i] = din[i] ^ inv[i];
  end

  always_comb begin
    y = pol[sel];
  end
endmodule

// File: rtl/mux4_le_out_stage.sv
module mux4_le_out_stage
  import mux4_le_pkg::*;
(
  input  logic      clk,
  input  logic      rst_q,
  input  out_mode_e mode,
  input  logic      comb_in,
  output logic      q,
  output logic      dout
);
  logic q_d;

  always_comb begin
    q_d = comb_in;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) q <= 1'b0;
    else        q <= q_d;
  end

  always_comb begin
    dout = (mode == OUT_REG) ? q : comb_in;
  end
endmodule

// File: rtl/mux4_le.sv
module mux4_le
  import mux4_le_pkg::*;
#(
  parameter int SEL_W      = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [SEL_W-1:0] sel,
  input  logic [3:0]       din,
  output logic             dout
);
  localparam int N_DAT = 1 << SEL_W;
  localparam int CFG_W = N_DAT + 1;

  logic             rst_q;
  logic [CFG_W-1:0] cfg_q;
  logic             mux_c;
  logic             reg_q;

  mux4_le_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .rst_q(rst_q)
  );

  mux4_le_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
    .clk     (clk),
    .shift_en(cfg_en),
    .shift_in(cfg_din),
    .cfg     (cfg_q)
  );

  mux4_le_datapath #(.SEL_W(SEL_W)) u_dp (
    .sel(sel),
    .din(din[N_DAT-1:0]),
    .inv(cfg_q[N_DAT-1:0]),
    .y  (mux_c)
  );

  mux4_le_out_stage u_out (
    .clk    (clk),
    .rst_q  (rst_q),
    .mode   (mode_of(cfg_q[CFG_W-1])),
    .comb_in(mux_c),
    .q      (reg_q),
    .dout   (dout)
  );
endmodule

// File: rtl/mux4_le_chk.sv
module mux4_le_chk #(
  parameter int CFG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_din,
  input logic [1:0]       sel,
  input logic [3:0]       din,
  input logic             dout,
  input logic [CFG_W-1:0] cfg_q,
  input logic             rst_q,
  input logic             mux_c
);
  assert_cfg_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_q == {$past(cfg_q[CFG_W-2:0]), $past(cfg_din)});

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_q));

  assert_comb_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[CFG_W-1] |-> dout == (din[sel] ^ cfg_q[sel]));

  assert_reg_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CFG_W-1] && rst_q && $past(rst_q)) |-> dout == $past(mux_c));

  assert_reset_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CFG_W-1] && !rst_q) |-> dout == 1'b0);
endmodule

bind mux4_le mux4_le_chk #(.CFG_W(CFG_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cfg_en (cfg_en),
  .cfg_din(cfg_din),
  .sel    (sel),
  .din    (din),
  .dout   (dout),
  .cfg_q  (cfg_q),
  .rst_q  (rst_q),
  .mux_c  (mux_c)
);

// File: tb/tb_mux4_le.sv
module tb_mux4_le;
  logic       clk;
  logic       rst_n;
  logic       cfg_en;
  logic       cfg_din;
  logic [1:0] sel;
  logic [3:0] din;
  logic       dout;

  int n_chk;
  int n_bad;
  logic [4:0] model_cfg;
  bit done;

  mux4_le dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .sel(sel), .din(din), .dout(dout)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  function automatic logic ref_out(input logic [4:0] c, input int s, input int d);
    int bitv;
    int invv;
    bitv = (d >> s) & 1;
    invv = c[s];
    return logic'(bitv != invv);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    cfg_en  = 1'b1;
    cfg_din = b;
    @(negedge clk);
    cfg_en  = 1'b0;
    model_cfg = {model_cfg[3:0], b};
  endtask

  task automatic load_cfg(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) shift_bit(c[i]);
  endtask

  // Combinational sweep over all 64 input combinations (R3, R4, R5)
  task automatic sweep_comb(input string tag);
    for (int v = 0; v < 64; v++) begin
      @(negedge clk);
      sel = 2'(v >> 4);
      din = 4'(v);
      #1;
      check(tag, dout, ref_out(model_cfg, v >> 4, v & 15));
    end
  endtask

  // Registered sweep (R6): output holds before the edge, updates after it
  task automatic sweep_reg(input string tag);
    logic prev;
    @(negedge clk);
    prev = ref_out(model_cfg, int'(sel), int'(din));
    @(posedge clk);
    for (int v = 0; v < 64; v++) begin
      @(negedge clk);
      sel = 2'(v >> 4);
      din = 4'(v);
      #1;
      check({tag, " hold"}, dout, prev);
      @(posedge clk);
      #1;
      prev = ref_out(model_cfg, v >> 4, v & 15);
      check(tag, dout, prev);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [4:0] c;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0; sel = '0; din = '0;
    model_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: serial load, MSB first, then the combinational function
    load_cfg(5'b0_1010);
    sweep_comb("R1 R3 R5 cfg 01010");
    load_cfg(5'b0_0000);
    sweep_comb("R3 no inversion");
    load_cfg(5'b0_1111);
    sweep_comb("R4 all inverted");
    load_cfg(5'b0_0100);
    sweep_comb("R4 single inversion");

    // R1: one extra shift moves the whole word up by one place
    load_cfg(5'b0_0011);
    shift_bit(1'b0);
    sweep_comb("R1 extra shift");

    // R2: cfg_din toggles with cfg_en low
    load_cfg(5'b0_1001);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cfg_din = ~cfg_din;
    end
    sweep_comb("R2 hold");

    // Two-input XOR: sel carries the variables, data lines carry the truth table
    load_cfg(5'b0_0000);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      sel = 2'(s);
      din = 4'b0110;
      #1;
      check("R3 two-input xor", dout, logic'(((s >> 1) ^ s) & 1));
    end

    // Random configurations in both modes
    for (int k = 0; k < 4; k++) begin
      c = 5'($urandom);
      c[4] = 1'b0;
      load_cfg(c);
      sweep_comb("R3 R4 random comb");
      c[4] = 1'b1;
      load_cfg(c);
      sweep_reg("R6 random reg");
    end

    // R7: reset behaviour in registered mode
    load_cfg(5'b1_0000);
    @(negedge clk);
    sel = 2'd2; din = 4'b0100;
    @(negedge clk);
    #1;
    check("R7 pre-reset", dout, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R7 async clear", dout, 1'b0);
    @(negedge clk);
    #1;
    check("R7 held in reset", dout, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R7 edge 1 after release", dout, 1'b0);
    @(posedge clk); #1;
    check("R7 edge 2 after release", dout, 1'b0);
    @(posedge clk); #1;
    check("R7 edge 3 after release", dout, 1'b1);

    // R8: configuration survives a reset pulse
    load_cfg(5'b0_0110);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sweep_comb("R8 cfg kept");

    done = 1'b1;
    summary();
  end
endmodule